// File: doc/BRIEF.md
# Save Area Header Fault Checker

This block screens a 64-byte save-area header, together with the machine state around it, before a privileged restore from a compacted save area is allowed to proceed. The header streams in as eight 64-bit words, one per accepted `word_valid_i` beat. Stall cycles between beats are allowed. Word 0 holds the present bitmap. Word 1 holds the compaction bitmap, whose top bit marks the compacted layout. Words 2 to 7 are reserved and must be zero.

When the eighth word is accepted, the checker samples several side inputs in that same cycle: the base address of the area, the privilege level, the user and supervisor enable masks, and the task-switched, OS-enable, feature-support and lock-prefix flags. One cycle later it issues a single verdict. The verdict carries an encoded fault class and, for protection faults, a sub-cause code. Segment limits, paging and address canonicality are checked elsewhere.

Top module: `hdr_fault_chk`

## Requirements
- R1: Accepted words are numbered 0 to 7 in arrival order, and the count wraps after word 7. `done_o` is high for exactly the one cycle that follows acceptance of word 7 and is low at all other times. Whenever `done_o` is low, `cause_o` and `gp_code_o` read 0.
- R2: A nonzero `priv_i` yields cause 1 (protection) with sub-cause 0.
- R3: If any of the low 6 bits of `base_addr_i` is set (the area is not 64-byte aligned), the result is cause 1 with sub-cause 1.
- R4: If bit 63 of the compaction bitmap (word 1) is 0, the result is cause 1 with sub-cause 2.
- R5: If any bit 0 to 62 of the compaction bitmap is set where `user_en_i | sup_en_i` is clear, the result is cause 1 with sub-cause 3.
- R6: If any bit of the present bitmap (word 0) is set where the compaction bitmap is clear, the result is cause 1 with sub-cause 4.
- R7: If any bit of words 2 to 7 is nonzero, the result is cause 1 with sub-cause 5.
- R8: A high `task_sw_i` yields cause 2 (device not available). This takes precedence over every protection check.
- R9: Cause 3 (undefined opcode) results from any of: `save_ok_i` low, `sup_save_ok_i` low, `os_en_i` low, or `lock_i` high. Cause 3 takes precedence over causes 2 and 1.
- R10: When several protection checks fail together, `gp_code_o` reports the lowest-numbered failing sub-cause.
- R11: When no check fails, the verdict is cause 0 with `gp_code_o` 0. `gp_code_o` is 0 whenever the cause is not 1.
- R12: Idle cycles between accepted words do not change the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | A header word is present this cycle |
| word_i | input | 64 | Header word |
| base_addr_i | input | ADDR_W | Base address of the save area |
| priv_i | input | 2 | Current privilege level |
| user_en_i | input | 64 | User-enabled feature mask |
| sup_en_i | input | 64 | Supervisor-enabled feature mask |
| task_sw_i | input | 1 | Task-switched flag |
| os_en_i | input | 1 | OS has enabled extended state handling |
| save_ok_i | input | 1 | Save feature is supported |
| sup_save_ok_i | input | 1 | Supervisor save feature is supported |
| lock_i | input | 1 | Lock prefix is present |
| done_o | output | 1 | Verdict valid (one-cycle pulse) |
| cause_o | output | 2 | 0 none, 1 protection, 2 device not available, 3 undefined opcode |
| gp_code_o | output | 3 | Protection sub-cause 0 to 5 |

## Verification
The hardest case to reach is a priority resolution in which several faults are present at once. Examples are a lock prefix on top of a task switch and a privilege fault, or a bad present bitmap combined with dirty reserved bytes. In these cases the lower-ranked fault must be masked completely, including its sub-cause. The vector table therefore stacks faults deliberately in several rows. Directed runs put the nonzero reserved word at the first reserved position instead of the last one, and insert idle cycles between beats, so that the reserved-byte accumulation is exercised across stalls.

// File: rtl/hfc_pkg.sv
package hfc_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_GP   = 2'd1,
    CAUSE_DNA  = 2'd2,
    CAUSE_UD   = 2'd3
  } cause_e;

  localparam int GP_CHECKS = 6;
  localparam int GP_CODE_W = 3;

  typedef enum logic [GP_CODE_W-1:0] {
    GP_PRIV      = 3'd0,
    GP_ALIGN     = 3'd1,
    GP_FMT       = 3'd2,
    GP_COMP_EN   = 3'd3,
    GP_PRES_COMP = 3'd4,
    GP_RSVD      = 3'd5
  } gp_code_e;
endpackage

// File: rtl/hfc_collector.sv
module hfc_collector #(
  parameter int WORD_W = 64,
  parameter int WORDS  = 8,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] present_o,
  output logic [WORD_W-1:0] compact_o,
  output logic              rsvd_nz_o,
  output logic              last_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] present_q, compact_q;
  logic              rsvd_q;
  logic              word_nz;

  assign word_nz = |word_i;
  assign last_o  = valid_i && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      present_q <= '0;
      compact_q <= '0;
      rsvd_q    <= 1'b0;
    end else if (valid_i) begin
      idx_q <= last_o ? '0 : idx_q + 1'b1;
      case (idx_q)
        IDX_W'(0): begin
          present_q <= word_i;
          rsvd_q    <= 1'b0;
        end
        IDX_W'(1): compact_q <= word_i;
        default:   rsvd_q    <= rsvd_q | word_nz;
      endcase
    end
  end

  // include the final word, which has not been registered yet
  assign rsvd_nz_o = rsvd_q | (last_o & word_nz);
  assign present_o = present_q;
  assign compact_o = compact_q;
  assign idx_o     = idx_q;
endmodule

// File: rtl/hfc_eval.sv
module hfc_eval
  import hfc_pkg::*;
#(
  parameter int MASK_W     = 64,
  parameter int ALIGN_BITS = 6
) (
  input  logic [MASK_W-1:0]     present_i,
  input  logic [MASK_W-1:0]     compact_i,
  input  logic                  rsvd_nz_i,
  input  logic [ALIGN_BITS-1:0] addr_lo_i,
  input  logic [1:0]            priv_i,
  input  logic [MASK_W-1:0]     user_en_i,
  input  logic [MASK_W-1:0]     sup_en_i,
  input  logic                  task_sw_i,
  input  logic                  os_en_i,
  input  logic                  save_ok_i,
  input  logic                  sup_save_ok_i,
  input  logic                  lock_i,
  output cause_e                cause_o,
  output logic [GP_CODE_W-1:0]  gp_code_o
);
  localparam int FMT_BIT = MASK_W - 1;
  localparam logic [MASK_W-1:0] FEAT_MASK = ~({{(MASK_W-1){1'b0}}, 1'b1} << FMT_BIT);

  logic [GP_CHECKS-1:0] gp_fail;
  logic                 ud_fail;
  logic [MASK_W-1:0]    enabled;

  assign enabled = user_en_i | sup_en_i;

  always_comb begin
    gp_fail               = '0;
    gp_fail[GP_PRIV]      = |priv_i;
    gp_fail[GP_ALIGN]     = |addr_lo_i;
    gp_fail[GP_FMT]       = ~compact_i[FMT_BIT];
    gp_fail[GP_COMP_EN]   = |(compact_i & ~enabled & FEAT_MASK);
    gp_fail[GP_PRES_COMP] = |(present_i & ~compact_i);
    gp_fail[GP_RSVD]      = rsvd_nz_i;
  end

  assign ud_fail = ~save_ok_i | ~sup_save_ok_i | ~os_en_i | lock_i;

  // lowest failing check wins
  logic [GP_CODE_W-1:0] gp_first;
  always_comb begin
    gp_first = '0;
    for (int i = GP_CHECKS - 1; i >= 0; i--) begin
      if (gp_fail[i]) gp_first = GP_CODE_W'(i);
    end
  end

  always_comb begin
    gp_code_o = '0;
    if (ud_fail)        cause_o = CAUSE_UD;
    else if (task_sw_i) cause_o = CAUSE_DNA;
    else if (|gp_fail) begin
      cause_o   = CAUSE_GP;
      gp_code_o = gp_first;
    end else            cause_o = CAUSE_NONE;
  end
endmodule

// File: rtl/hdr_fault_chk.sv
module hdr_fault_chk
  import hfc_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int MASK_W     = 64,
  parameter int HDR_BYTES  = 64,
  parameter int WORD_BYTES = 8,
  localparam int WORD_W     = WORD_BYTES * 8,
  localparam int WORDS      = HDR_BYTES / WORD_BYTES,
  localparam int ALIGN_BITS = $clog2(HDR_BYTES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 word_valid_i,
  input  logic [WORD_W-1:0]    word_i,
  input  logic [ADDR_W-1:0]    base_addr_i,
  input  logic [1:0]           priv_i,
  input  logic [MASK_W-1:0]    user_en_i,
  input  logic [MASK_W-1:0]    sup_en_i,
  input  logic                 task_sw_i,
  input  logic                 os_en_i,
  input  logic                 save_ok_i,
  input  logic                 sup_save_ok_i,
  input  logic                 lock_i,
  output logic                 done_o,
  output logic [1:0]           cause_o,
  output logic [GP_CODE_W-1:0] gp_code_o
);
  localparam int IDX_W = $clog2(WORDS);

  logic [WORD_W-1:0]    present_w, compact_w;
  logic                 rsvd_nz_w, last_w;
  logic [IDX_W-1:0]     idx_w;
  cause_e               cause_w;
  logic [GP_CODE_W-1:0] code_w;
  logic                 unused_addr;

  assign unused_addr = ^base_addr_i[ADDR_W-1:ALIGN_BITS];

  hfc_collector #(.WORD_W(WORD_W), .WORDS(WORDS)) u_coll (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (word_valid_i),
    .word_i    (word_i),
    .present_o (present_w),
    .compact_o (compact_w),
    .rsvd_nz_o (rsvd_nz_w),
    .last_o    (last_w),
    .idx_o     (idx_w)
  );

  hfc_eval #(.MASK_W(MASK_W), .ALIGN_BITS(ALIGN_BITS)) u_eval (
    .present_i     (present_w[MASK_W-1:0]),
    .compact_i     (compact_w[MASK_W-1:0]),
    .rsvd_nz_i     (rsvd_nz_w),
    .addr_lo_i     (base_addr_i[ALIGN_BITS-1:0]),
    .priv_i        (priv_i),
    .user_en_i     (user_en_i),
    .sup_en_i      (sup_en_i),
    .task_sw_i     (task_sw_i),
    .os_en_i       (os_en_i),
    .save_ok_i     (save_ok_i),
    .sup_save_ok_i (sup_save_ok_i),
    .lock_i        (lock_i),
    .cause_o       (cause_w),
    .gp_code_o     (code_w)
  );

  logic                 done_q;
  cause_e               cause_q;
  logic [GP_CODE_W-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
      code_q  <= '0;
    end else begin
      done_q  <= last_w;
      cause_q <= last_w ? cause_w : CAUSE_NONE;
      code_q  <= last_w ? code_w : '0;
    end
  end

  assign done_o    = done_q;
  assign cause_o   = cause_q;
  assign gp_code_o = code_q;
endmodule

// File: rtl/hfc_checker.sv
module hfc_checker #(
  parameter int IDX_W = 3,
  parameter int WORDS = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             word_valid_i,
  input logic [IDX_W-1:0] idx_i,
  input logic [1:0]       priv_i,
  input logic             task_sw_i,
  input logic             os_en_i,
  input logic             save_ok_i,
  input logic             sup_save_ok_i,
  input logic             lock_i,
  input logic             done_o,
  input logic [1:0]       cause_o,
  input logic [2:0]       gp_code_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  AST_DONE_FOLLOWS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_valid_i && idx_i == LAST) |=> done_o); // R1
  AST_DONE_NEEDS_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(word_valid_i && idx_i == LAST)); // R1
  AST_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (cause_o == 2'd0 && gp_code_o == 3'd0)); // R1
  AST_UD_ON_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(lock_i)) |-> cause_o == 2'd3); // R9
  AST_DNA_OVER_GP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(task_sw_i && !lock_i && os_en_i && save_ok_i && sup_save_ok_i))
      |-> cause_o == 2'd2); // R8
  AST_PRIV_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cause_o == 2'd1 && $past(priv_i != 2'd0)) |-> gp_code_o == 3'd0); // R10
  AST_CODE_ONLY_GP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cause_o != 2'd1) |-> gp_code_o == 3'd0); // R11
endmodule

bind hdr_fault_chk hfc_checker #(.IDX_W(IDX_W), .WORDS(WORDS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .word_valid_i  (word_valid_i),
  .idx_i         (idx_w),
  .priv_i        (priv_i),
  .task_sw_i     (task_sw_i),
  .os_en_i       (os_en_i),
  .save_ok_i     (save_ok_i),
  .sup_save_ok_i (sup_save_ok_i),
  .lock_i        (lock_i),
  .done_o        (done_o),
  .cause_o       (cause_o),
  .gp_code_o     (gp_code_o)
);

// File: tb/hdr_fault_chk_bench.sv
`timescale 1ns/1ps
module hdr_fault_chk_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [63:0] word = '0;
  logic [47:0] base = '0;
  logic [1:0]  priv = '0;
  logic [63:0] uen = 64'h7;
  logic [63:0] sen = 64'h100;
  logic        ts = 1'b0, os = 1'b1, sv = 1'b1, ssv = 1'b1, lk = 1'b0;
  logic        done;
  logic [1:0]  cause;
  logic [2:0]  code;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  hdr_fault_chk u_hdr_fault_chk (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(vld), .word_i(word),
    .base_addr_i(base), .priv_i(priv), .user_en_i(uen), .sup_en_i(sen),
    .task_sw_i(ts), .os_en_i(os), .save_ok_i(sv), .sup_save_ok_i(ssv),
    .lock_i(lk), .done_o(done), .cause_o(cause), .gp_code_o(code)
  );

  localparam logic [63:0] GOOD_C = 64'h8000_0000_0000_0103;
  localparam logic [63:0] GOOD_P = 64'h3;

  // flags = {task_sw, save_ok, sup_save_ok, os_en, lock}; all-clear good = 5'b01110
  typedef struct packed {
    logic [63:0] pres;
    logic [63:0] comp;
    logic [63:0] rsv;
    logic [1:0]  pl;
    logic [5:0]  alo;
    logic [4:0]  flg;
    logic [1:0]  exp_cause;
    logic [2:0]  exp_code;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{GOOD_P, GOOD_C, 64'h0, 2'd0, 6'h00, 5'b01110, 2'd0, 3'd0}, // R11
    '{GOOD_P, GOOD_C, 64'h0, 2'd3, 6'h00, 5'b01110, 2'd1, 3'd0}, // R2
    '{GOOD_P, GOOD_C, 64'h0, 2'd0, 6'h20, 5'b01110, 2'd1, 3'd1}, // R3
    '{GOOD_P, 64'h103, 64'h0, 2'd0, 6'h00, 5'b01110, 2'd1, 3'd2}, // R4
    '{GOOD_P, GOOD_C | 64'h10, 64'h0, 2'd0, 6'h00, 5'b01110, 2'd1, 3'd3}, // R5
    '{64'h4, GOOD_C, 64'h0, 2'd0, 6'h00, 5'b01110, 2'd1, 3'd4}, // R6
    '{GOOD_P, GOOD_C, 64'h1, 2'd0, 6'h00, 5'b01110, 2'd1, 3'd5}, // R7
    '{GOOD_P, GOOD_C, 64'h0, 2'd0, 6'h00, 5'b11110, 2'd2, 3'd0}, // R8
    '{GOOD_P, GOOD_C, 64'h0, 2'd1, 6'h01, 5'b11110, 2'd2, 3'd0}, // R8
    '{GOOD_P, GOOD_C, 64'h0, 2'd0, 6'h00, 5'b01111, 2'd3, 3'd0}, // R9
    '{GOOD_P, GOOD_C, 64'h0, 2'd2, 6'h00, 5'b11100, 2'd3, 3'd0}, // R9
    '{GOOD_P, GOOD_C, 64'h0, 2'd0, 6'h00, 5'b00110, 2'd3, 3'd0}, // R9
    '{GOOD_P, GOOD_C, 64'h0, 2'd0, 6'h00, 5'b01010, 2'd3, 3'd0}, // R9
    '{GOOD_P, GOOD_C, 64'h8, 2'd1, 6'h08, 5'b01110, 2'd1, 3'd0}, // R10
    '{64'h4, GOOD_C, 64'hF0, 2'd0, 6'h00, 5'b01110, 2'd1, 3'd4}, // R10
    '{GOOD_P, 64'h113, 64'h0, 2'd0, 6'h00, 5'b01110, 2'd1, 3'd2}  // R10
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sends a header, checks the verdict one cycle after the last word
  task automatic run_hdr(input vec_t v, input int rsv_pos, input bit gaps, input string req);
    priv = v.pl;
    base = {42'h1234, v.alo};
    {ts, sv, ssv, os, lk} = v.flg;
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      if (w == 7) chk({req, " done low before last"}, int'(done), 0);
      vld  = 1'b1;
      word = (w == 0) ? v.pres : (w == 1) ? v.comp : (w == rsv_pos) ? v.rsv : 64'h0;
      if (gaps && w < 7) begin
        @(negedge clk);
        vld  = 1'b0;
        word = 64'hFFFF_FFFF_FFFF_FFFF;
      end
    end
    @(negedge clk);
    vld = 1'b0;
    chk({req, " done"}, int'(done), 1);
    chk({req, " cause"}, int'(cause), int'(v.exp_cause));
    chk({req, " code"}, int'(code), int'(v.exp_code));
    @(negedge clk);
    chk("R1 done pulse ends", int'(done), 0);
    chk("R1 cause idle", int'(cause), 0);
  endtask

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset cause", int'(cause), 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_hdr(VECS[i], 7, 1'b0, $sformatf("vec%0d", i));
    // R12: stalls between beats
    run_hdr(VECS[0], 7, 1'b1, "R12 good with gaps");
    // R7: reserved word in first reserved slot, with stalls
    d = VECS[6];
    d.rsv = 64'h8000_0000_0000_0000;
    run_hdr(d, 2, 1'b1, "R7 first reserved slot");
    // R5: feature bit enabled only by supervisor mask passes
    d = VECS[0];
    d.comp = GOOD_C;
    d.pres = 64'h100;
    run_hdr(d, 7, 1'b0, "R5 supervisor-enabled ok");
    // R1: count restarts correctly after reset mid-header
    @(negedge clk); vld = 1'b1; word = GOOD_P;
    @(negedge clk); vld = 1'b0;
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    run_hdr(VECS[4], 7, 1'b0, "R1 restart after reset");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule